// File: doc/BRIEF.md
# Handshake Side-Channel Update Scheduler

This block carries three slow control lines across a burst-based link as plain data. The lines are request-to-send, data-terminal-ready and a ring indicator. The local inputs are resynchronised, and the block decides when a fresh snapshot of them must go into the next outgoing burst. It raises a request that the burst assembler acknowledges, and it presents the current snapshot word beside that request. It raises the request for either of two reasons: a free-running interval timer expires, or an edge appears on request-to-send or data-terminal-ready. The request and the timer both work on the crystal clock. When a request is issued because of an edge, the timer starts again from zero.

On the receive side, each valid snapshot strobe from the link loads the far-end outputs: clear-to-send, data-set-ready and the ring-indicator output. No local handshaking takes place. Each line passes straight through the link. The default interval is 16000 crystal cycles, which is about 1.6 ms with a 10 MHz crystal.

Top module: `hs_link_sched`

## Requirements
- R1: While reset is asserted and after it, until the first trigger, `snap_req_o`, `cts_o`, `dsr_o` and `rio_o` are low.
- R2: `snap_data_o` shows the local inputs two clock edges after they change, with bit 0 = RTS, bit 1 = DTR and bit 2 = ring indicator.
- R3: A change on RTS or DTR raises `snap_req_o` on the third rising edge after the change, and not before.
- R4: A change on the ring-indicator input alone raises no request, although it does appear in bit 2 of `snap_data_o`.
- R5: With no input changes and with every request acknowledged, `snap_req_o` rises once every `INTERVAL` cycles.
- R6: After a request caused by a change, the next timer request rises exactly `INTERVAL` cycles later.
- R7: A request stays high until `snap_ack_i` is sampled high. It falls on that edge when no new trigger occurs in the same cycle.
- R8: A trigger in the same cycle as an acknowledge leaves `snap_req_o` high.
- R9: Several triggers that arrive while a request is pending merge into that one request, so a single acknowledge clears it.
- R10: When `rx_valid_i` is high on an edge, the outputs take `cts_o` = bit 0, `dsr_o` = bit 1 and `rio_o` = bit 2 of `rx_data_i`.
- R11: When `rx_valid_i` is low, the outputs hold their values whatever `rx_data_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rts_i | input | 1 | Local request-to-send |
| dtr_i | input | 1 | Local data-terminal-ready |
| ri_i | input | 1 | Local ring indicator |
| snap_ack_i | input | 1 | Burst assembler has taken the snapshot |
| rx_valid_i | input | 1 | Received snapshot strobe |
| rx_data_i | input | 3 | Received snapshot word |
| snap_req_o | output | 1 | Snapshot insertion request |
| snap_data_o | output | 3 | Current synchronised snapshot word |
| cts_o | output | 1 | Far-end clear-to-send |
| dsr_o | output | 1 | Far-end data-set-ready |
| rio_o | output | 1 | Far-end ring-indicator output |

## Verification
Two events can fall in the same cycle: a new trigger, and the acknowledge that retires the pending request. The bench times a second RTS or DTR edge so that the detected change lands exactly in the cycle when the acknowledge is sampled. It then requires that the request is still high one edge later. The merging rule is judged separately. Several changes are stacked on one pending request, and a single acknowledge must then leave the request low until the next timer expiry.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int CH_W    = 3;
  localparam int IDX_RTS = 0;
  localparam int IDX_DTR = 1;
  localparam int IDX_RI  = 2;
  typedef logic [CH_W-1:0] hs_word_t;
  // lines whose edges force an immediate snapshot
  localparam hs_word_t TRIG_MASK = hs_word_t'((1 << IDX_RTS) | (1 << IDX_DTR));
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/hs_interval_timer.sv
module hs_interval_timer #(
  parameter int INTERVAL = 16000,
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic          tick_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hs_req_ctrl.sv
module hs_req_ctrl (
  input  logic clk_i,
  input  logic rst_n,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q, req_d;

  // a new trigger wins over a simultaneous acknowledge
  always_comb begin
    if (trig_i)     req_d = 1'b1;
    else if (ack_i) req_d = 1'b0;
    else            req_d = req_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/hs_rx_hold.sv
module hs_rx_hold #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb q_d = valid_i ? data_i : q_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/hs_link_sched.sv
module hs_link_sched #(
  parameter int INTERVAL = 16000,
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rts_i,
  input  logic       dtr_i,
  input  logic       ri_i,
  input  logic       snap_ack_i,
  input  logic       rx_valid_i,
  input  logic [2:0] rx_data_i,
  output logic       snap_req_o,
  output logic [2:0] snap_data_o,
  output logic       cts_o,
  output logic       dsr_o,
  output logic       rio_o
);
  import hs_pkg::*;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  hs_word_t raw_in, sync_w, prev_q, prev_d;
  logic     chg, tick, trig;
  logic [CW-1:0] tmr_cnt;
  hs_word_t rx_w;

  always_comb begin
    raw_in          = '0;
    raw_in[IDX_RTS] = rts_i;
    raw_in[IDX_DTR] = dtr_i;
    raw_in[IDX_RI]  = ri_i;
  end

  hs_sync #(.W(CH_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n_q),
    .d_i   (raw_in),
    .q_o   (sync_w)
  );

  // edge detection on the triggering lines
  always_comb begin
    prev_d = sync_w;
    chg    = |((sync_w ^ prev_q) & TRIG_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) prev_q <= '0;
    else          prev_q <= prev_d;
  end

  hs_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
    .clk_i     (clk_i),
    .rst_n     (rst_n_q),
    .restart_i (chg),
    .tick_o    (tick),
    .cnt_o     (tmr_cnt)
  );

  assign trig = chg | tick;

  hs_req_ctrl u_req (
    .clk_i  (clk_i),
    .rst_n  (rst_n_q),
    .trig_i (trig),
    .ack_i  (snap_ack_i),
    .req_o  (snap_req_o)
  );

  assign snap_data_o = sync_w;

  hs_rx_hold #(.W(CH_W)) u_rx (
    .clk_i   (clk_i),
    .rst_n   (rst_n_q),
    .valid_i (rx_valid_i),
    .data_i  (rx_data_i),
    .q_o     (rx_w)
  );

  assign cts_o = rx_w[IDX_RTS];
  assign dsr_o = rx_w[IDX_DTR];
  assign rio_o = rx_w[IDX_RI];
endmodule

// File: rtl/hs_link_sched_chk.sv
module hs_link_sched_chk #(
  parameter int INTERVAL = 16000,
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          req,
  input logic          ack,
  input logic          trig,
  input logic          rx_valid,
  input logic [2:0]    rx_data,
  input logic          cts,
  input logic          dsr,
  input logic          rio,
  input logic [CW-1:0] cnt
);
  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    req && !ack |=> req);
  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    req && ack && !trig |=> !req);
  p_trig_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    trig |=> req);
  p_rx_load_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_valid |=> ({rio, dsr, cts} == $past(rx_data)));
  p_rx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rx_valid |=> $stable({rio, dsr, cts}));
  p_tmr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= CW'(INTERVAL - 1));
endmodule

bind hs_link_sched hs_link_sched_chk #(.INTERVAL(INTERVAL)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_q),
  .req      (snap_req_o),
  .ack      (snap_ack_i),
  .trig     (trig),
  .rx_valid (rx_valid_i),
  .rx_data  (rx_data_i),
  .cts      (cts_o),
  .dsr      (dsr_o),
  .rio      (rio_o),
  .cnt      (tmr_cnt)
);

// File: tb/sim_hs_link_sched.sv
`timescale 1ns/1ps
module sim_hs_link_sched;
  localparam int IV = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rts_i = 1'b0, dtr_i = 1'b0, ri_i = 1'b0;
  logic       snap_ack_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [2:0] rx_data_i = 3'd0;
  logic       snap_req_o;
  logic [2:0] snap_data_o;
  logic       cts_o, dsr_o, rio_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  hs_link_sched #(.INTERVAL(IV)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rts_i(rts_i), .dtr_i(dtr_i), .ri_i(ri_i),
    .snap_ack_i(snap_ack_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .snap_req_o(snap_req_o), .snap_data_o(snap_data_o),
    .cts_o(cts_o), .dsr_o(dsr_o), .rio_o(rio_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [2:0] v);
    rts_i = v[0]; dtr_i = v[1]; ri_i = v[2];
  endtask

  task automatic ack_once();
    snap_ack_i = 1'b1;
    @(negedge clk_i);
    snap_ack_i = 1'b0;
  endtask

  // count cycles from a rise seen at this negedge to the next rise, acking each
  task automatic measure(output int n);
    n = 0;
    ack_once();
    n = 1;
    while (!snap_req_o && n < 4 * IV) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [2:0] prev;
    logic [2:0] seq [11];
    int n;
    seq = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd3, 3'd7, 3'd0};

    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk("R1 req in reset", snap_req_o, 0);
    chk("R1 outputs in reset", {rio_o, dsr_o, cts_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 req after reset", snap_req_o, 0);
    chk("R1 outputs after reset", {rio_o, dsr_o, cts_o}, 0);

    // align to the timer: wait for its first request and retire it
    n = 0;
    while (!snap_req_o && n < 4 * IV) begin @(negedge clk_i); n++; end
    chk("R5 first timer request", snap_req_o, 1);
    ack_once();

    // R2/R3/R4/R7 sweep over every input word and some ring-only steps
    prev = 3'd0;
    for (int i = 1; i < 11; i++) begin
      logic [2:0] v;
      logic       exp_req;
      v = seq[i];
      exp_req = ((v ^ prev) & 3'b011) != 3'b000;
      set_in(v);
      @(negedge clk_i);
      @(negedge clk_i);
      chk("R3 no early request", snap_req_o, 0);
      chk("R2 data after two edges", snap_data_o, v);
      @(negedge clk_i);
      if (exp_req) chk("R3 request on third edge", snap_req_o, 1);
      else         chk("R4 ring-only change ignored", snap_req_o, 0);
      if (snap_req_o) begin
        repeat (2) @(negedge clk_i);
        chk("R7 request held without ack", snap_req_o, 1);
        ack_once();
        chk("R7 request cleared by ack", snap_req_o, 0);
      end
      prev = v;
    end

    // R6: timer restart after a change-triggered request; R5: free running
    set_in(3'd1);
    repeat (3) @(negedge clk_i);
    chk("R3 request before restart check", snap_req_o, 1);
    measure(n);
    chk("R6 interval after change request", n, IV);
    measure(n);
    chk("R5 free-running interval", n, IV);
    measure(n);
    chk("R5 free-running interval again", n, IV);
    ack_once();

    // R8: a change detected in the very cycle of the acknowledge
    set_in(3'd3);
    repeat (3) @(negedge clk_i);
    chk("R8 first request pending", snap_req_o, 1);
    set_in(3'd1);
    repeat (2) @(negedge clk_i);
    snap_ack_i = 1'b1;
    @(negedge clk_i);
    snap_ack_i = 1'b0;
    chk("R8 trigger beats ack", snap_req_o, 1);
    ack_once();
    chk("R8 later ack clears", snap_req_o, 0);

    // R9: stacked changes on one pending request
    set_in(3'd0);
    repeat (3) @(negedge clk_i);
    set_in(3'd2);
    repeat (3) @(negedge clk_i);
    set_in(3'd3);
    repeat (4) @(negedge clk_i);
    chk("R9 pending before ack", snap_req_o, 1);
    ack_once();
    chk("R9 single ack clears", snap_req_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R9 no queued request", snap_req_o, 0);

    // R10/R11: receive side over every word
    for (int v = 0; v < 8; v++) begin
      rx_data_i = 3'(v);
      rx_valid_i = 1'b1;
      @(negedge clk_i);
      rx_valid_i = 1'b0;
      chk("R10 cts bit0", cts_o, v & 1);
      chk("R10 dsr bit1", dsr_o, (v >> 1) & 1);
      chk("R10 rio bit2", rio_o, (v >> 2) & 1);
      rx_data_i = ~3'(v);
      repeat (2) @(negedge clk_i);
      chk("R11 hold without valid", {rio_o, dsr_o, cts_o}, v);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule